// File: doc/BRIEF.md
# Transmit Descriptor Chain DMA

This block moves outgoing frames from memory to a byte stream. Software builds a linked list of three-word descriptors in memory: a buffer pointer, a size word and a pointer to the next descriptor. It loads the list head into the base register and then writes the DMA enable bit. If the MAC transmit enable input is high, the block walks the list over a 32-bit word bus. For each descriptor still owned by the hardware, it streams the frame bytes out with first-byte and last-byte markers. It then writes the size word back with the ownership bit set, so that software can reclaim the buffer, and moves on to the next descriptor.

The walk ends at the first descriptor whose ownership bit is already set. The block reports this as an underrun and drops its own enable bit. A loopback input selects, one frame at a time, whether a frame leaves on the line stream or on the loopback stream that feeds the receive side. Framing, preamble and inter-frame gap are handled downstream.

The controller is one state machine with these states: IDLE, RD_BUF, RD_SIZE, RD_NEXT, FETCH, EMIT, WRBACK, ADVANCE and UNDERRUN. Its transitions are:
- IDLE to RD_BUF on an accepted start.
- RD_BUF to RD_SIZE when the read is acknowledged.
- RD_SIZE to UNDERRUN when the size word has bit 31 set, otherwise to RD_NEXT.
- RD_NEXT to WRBACK for a zero length, otherwise to FETCH.
- FETCH to EMIT when the word arrives.
- EMIT stays in EMIT for the next byte in the same word, goes to FETCH when the frame crosses a word boundary, and goes to WRBACK after the last byte.
- WRBACK to ADVANCE when the write is acknowledged.
- ADVANCE to RD_BUF.
- UNDERRUN to IDLE.

Top module: `txd_chain_dma`

## Requirements
- R1: A write with `kick_wr` high stores `kick_bit` into `dma_en` when no walk is running. A walk starts only if `kick_bit` is 1 and `mac_tx_on` is high. With `mac_tx_on` low, `dma_en` becomes 1 and no bus request is made.
- R2: A base write stores `base_wdata` with bits 1:0 forced to zero. Every bus address is word aligned. For a descriptor at address D, the words are read in this order: buffer pointer at D, size word at D+4, next pointer at D+8.
- R3: A size word with bit 31 set ends the walk. The next pointer of that descriptor is not read. `underrun_pulse` is high for one cycle, `dma_en` then reads 0, and the bus stays idle.
- R4: A descriptor with bit 31 clear sends exactly the count held in bits 10:0 of its size word, starting at the buffer pointer and going up in address order. The byte at address A is bits 8k+7:8k of the word at A with its low two bits cleared, where k is A[1:0]. Each word is fetched once per frame. The marker `*_sof` is set on the first byte and `*_eof` on the last byte.
- R5: After the last byte, the size word is written back to D+4 with bit 31 set and all other bits unchanged. Then `sent_pulse` is high for one cycle, and the walk continues at the next pointer.
- R6: The loopback input is sampled once per frame, when the next pointer is read. While it is 1, the whole frame goes to the loopback stream and `line_valid` stays low. While it is 0, the whole frame goes to the line stream. The two valids are never high together.
- R7: While the selected sink holds ready low, the byte, its markers and valid stay unchanged, and the walk pauses.
- R8: A descriptor with length 0 sends no byte and no marker. It is still written back and still produces `sent_pulse`.
- R9: A bus request keeps its address, write flag and write data unchanged until `mem_ack`.
- R10: Enable writes made while a walk is running are ignored: `dma_en` stays 1 and the walk continues unchanged.
- R11: After reset, `dma_en`, `mem_req`, `line_valid` and `lb_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mac_tx_on | input | 1 | MAC transmit enable; a walk starts only while it is high |
| loop_on | input | 1 | Loopback select, sampled once per frame |
| base_wr | input | 1 | Write strobe for the descriptor base register |
| base_wdata | input | 32 | Base address data; bits 1:0 are dropped |
| kick_wr | input | 1 | Write strobe for the DMA enable bit |
| kick_bit | input | 1 | Value written to the DMA enable bit |
| dma_en | output | 1 | Current DMA enable bit |
| mem_req | output | 1 | Bus request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Word-aligned bus address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle completion of the pending request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| line_valid | output | 1 | Line stream byte valid |
| line_ready | input | 1 | Line sink ready |
| line_data | output | 8 | Line stream byte |
| line_sof | output | 1 | First byte of the frame on the line stream |
| line_eof | output | 1 | Last byte of the frame on the line stream |
| lb_valid | output | 1 | Loopback stream byte valid |
| lb_ready | input | 1 | Loopback sink ready |
| lb_data | output | 8 | Loopback stream byte |
| lb_sof | output | 1 | First byte of the frame on the loopback stream |
| lb_eof | output | 1 | Last byte of the frame on the loopback stream |
| sent_pulse | output | 1 | One cycle per completed descriptor |
| underrun_pulse | output | 1 | One cycle when the walk meets an empty descriptor |

## Verification
The properties assume a memory that raises `mem_ack` for exactly one cycle, only while a request is pending, and never in the cycle right after a previous acknowledge. They also assume that the sinks may lower ready at any time. The bench memory acknowledges every request on the second edge after it appears, so it stays inside that contract. The sink readiness is driven from a pseudo-random sequence that changes on falling edges, which exercises pauses in the middle of a frame without ever breaking the bus contract. The stimulus sweeps every frame length in a small set against all four buffer byte offsets. It also includes odd descriptors whose size word has a stray bit 11.

// File: rtl/txd_pkg.sv
package txd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_BUF,
        ST_RD_SIZE,
        ST_RD_NEXT,
        ST_FETCH,
        ST_EMIT,
        ST_WRBACK,
        ST_ADVANCE,
        ST_UNDERRUN
    } walk_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       sof;
        logic       eof;
    } beat_t;

endpackage

// File: rtl/txd_cfg_regs.sv
module txd_cfg_regs #(
    parameter int unsigned AW = 32,
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mac_tx_on,
    input  logic          base_wr,
    input  logic [AW-1:0] base_wdata,
    input  logic          kick_wr,
    input  logic          kick_bit,
    input  logic          walk_busy,
    input  logic          walk_done,
    output logic [AW-1:0] base_addr,
    output logic          dma_en,
    output logic          start
);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(WORD_BYTES - 1);

    logic [AW-1:0] base_q;
    logic          en_q;

    // A start needs an idle walker, a 1 written and the MAC transmitter enabled
    assign start     = kick_wr && kick_bit && mac_tx_on && !walk_busy;
    assign base_addr = base_q;
    assign dma_en    = en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            en_q   <= 1'b0;
        end else begin
            if (base_wr) begin
                base_q <= base_wdata & ALIGN_MASK;
            end
            if (walk_done) begin
                en_q <= 1'b0;
            end else if (kick_wr && !walk_busy) begin
                en_q <= kick_bit;
            end
        end
    end
endmodule

// File: rtl/txd_lane_pick.sv
module txd_lane_pick #(
    parameter int unsigned DW = 32,
    localparam int unsigned LANES = DW / 8,
    localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [DW-1:0]     word,
    input  logic [LANE_W-1:0] lane,
    output logic [7:0]        byte_o
);
    logic [7:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    assign byte_o = lanes[lane];
endmodule

// File: rtl/txd_out_steer.sv
module txd_out_steer
    import txd_pkg::*;
(
    input  logic       beat_valid,
    input  beat_t      beat,
    input  logic       to_loop,
    output logic       beat_ready,
    output logic       line_valid,
    input  logic       line_ready,
    output logic [7:0] line_data,
    output logic       line_sof,
    output logic       line_eof,
    output logic       lb_valid,
    input  logic       lb_ready,
    output logic [7:0] lb_data,
    output logic       lb_sof,
    output logic       lb_eof
);
    always_comb begin
        line_valid = beat_valid && !to_loop;
        lb_valid   = beat_valid && to_loop;
        line_data  = beat.data;
        lb_data    = beat.data;
        line_sof   = beat.sof && !to_loop;
        line_eof   = beat.eof && !to_loop;
        lb_sof     = beat.sof && to_loop;
        lb_eof     = beat.eof && to_loop;
        beat_ready = to_loop ? lb_ready : line_ready;
    end
endmodule

// File: rtl/txd_walk_fsm.sv
module txd_walk_fsm
    import txd_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32,
    parameter int unsigned LEN_W = 11,
    parameter int unsigned EMPTY_BIT = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic          loop_on,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          beat_valid,
    output beat_t         beat,
    output logic          to_loop,
    input  logic          beat_ready,
    output logic          sent_pulse,
    output logic          underrun_pulse,
    output logic          walk_busy,
    output logic          walk_done
);
    localparam int unsigned   WB         = DW / 8;
    localparam int unsigned   LANE_W     = (WB > 1) ? $clog2(WB) : 1;
    localparam logic [AW-1:0] OFS_SIZE   = AW'(WB);
    localparam logic [AW-1:0] OFS_NEXT   = AW'(2 * WB);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(WB - 1);
    localparam logic [DW-1:0] OWN_FLAG   = DW'(1) << EMPTY_BIT;

    walk_state_t      state_q, state_d;
    logic [AW-1:0]    desc_q;
    logic [AW-1:0]    buf_q;
    logic [AW-1:0]    next_q;
    logic [DW-1:0]    size_q;
    logic [DW-1:0]    word_q;
    logic [LEN_W-1:0] remain_q;
    logic             first_q;
    logic             loop_q;
    logic [7:0]       lane_byte;
    logic             last_beat;

    assign last_beat = (remain_q == LEN_W'(1));

    txd_lane_pick #(.DW(DW)) u_lane (
        .word   (word_q),
        .lane   (buf_q[LANE_W-1:0]),
        .byte_o (lane_byte)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_RD_BUF;
            ST_RD_BUF:   if (mem_ack) state_d = ST_RD_SIZE;
            ST_RD_SIZE: begin
                if (mem_ack) begin
                    state_d = mem_rdata[EMPTY_BIT] ? ST_UNDERRUN : ST_RD_NEXT;
                end
            end
            ST_RD_NEXT: begin
                if (mem_ack) begin
                    state_d = (size_q[LEN_W-1:0] == '0) ? ST_WRBACK : ST_FETCH;
                end
            end
            ST_FETCH:    if (mem_ack) state_d = ST_EMIT;
            ST_EMIT: begin
                if (beat_ready) begin
                    if (last_beat) begin
                        state_d = ST_WRBACK;
                    end else if (&buf_q[LANE_W-1:0]) begin
                        state_d = ST_FETCH;
                    end else begin
                        state_d = ST_EMIT;
                    end
                end
            end
            ST_WRBACK:   if (mem_ack) state_d = ST_ADVANCE;
            ST_ADVANCE:  state_d = ST_RD_BUF;
            ST_UNDERRUN: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register and walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            desc_q   <= '0;
            buf_q    <= '0;
            next_q   <= '0;
            size_q   <= '0;
            word_q   <= '0;
            remain_q <= '0;
            first_q  <= 1'b0;
            loop_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            case (state_q)
                ST_IDLE:    if (start) desc_q <= base_addr;
                ST_RD_BUF:  if (mem_ack) buf_q <= AW'(mem_rdata);
                ST_RD_SIZE: if (mem_ack) size_q <= mem_rdata;
                ST_RD_NEXT: begin
                    if (mem_ack) begin
                        next_q   <= AW'(mem_rdata) & ALIGN_MASK;
                        remain_q <= size_q[LEN_W-1:0];
                        first_q  <= 1'b1;
                        loop_q   <= loop_on;
                    end
                end
                ST_FETCH:   if (mem_ack) word_q <= mem_rdata;
                ST_EMIT: begin
                    if (beat_ready) begin
                        buf_q    <= buf_q + AW'(1);
                        remain_q <= remain_q - LEN_W'(1);
                        first_q  <= 1'b0;
                    end
                end
                ST_ADVANCE: desc_q <= next_q;
                default: ;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        mem_req        = 1'b0;
        mem_we         = 1'b0;
        mem_addr       = '0;
        mem_wdata      = '0;
        beat_valid     = 1'b0;
        sent_pulse     = 1'b0;
        underrun_pulse = 1'b0;
        walk_done      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD_BUF: begin
                mem_req  = 1'b1;
                mem_addr = desc_q;
            end
            ST_RD_SIZE: begin
                mem_req  = 1'b1;
                mem_addr = desc_q + OFS_SIZE;
            end
            ST_RD_NEXT: begin
                mem_req  = 1'b1;
                mem_addr = desc_q + OFS_NEXT;
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = buf_q & ALIGN_MASK;
            end
            ST_EMIT:    beat_valid = 1'b1;
            ST_WRBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_q + OFS_SIZE;
                mem_wdata = size_q | OWN_FLAG;
            end
            ST_ADVANCE: sent_pulse = 1'b1;
            ST_UNDERRUN: begin
                underrun_pulse = 1'b1;
                walk_done      = 1'b1;
            end
            default: ;
        endcase
    end

    assign beat.data = lane_byte;
    assign beat.sof  = first_q;
    assign beat.eof  = last_beat;
    assign to_loop   = loop_q;
    assign walk_busy = (state_q != ST_IDLE);
endmodule

// File: rtl/txd_chain_dma.sv
module txd_chain_dma
    import txd_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32,
    parameter int unsigned LEN_W = 11,
    parameter int unsigned EMPTY_BIT = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mac_tx_on,
    input  logic          loop_on,
    input  logic          base_wr,
    input  logic [AW-1:0] base_wdata,
    input  logic          kick_wr,
    input  logic          kick_bit,
    output logic          dma_en,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          line_valid,
    input  logic          line_ready,
    output logic [7:0]    line_data,
    output logic          line_sof,
    output logic          line_eof,
    output logic          lb_valid,
    input  logic          lb_ready,
    output logic [7:0]    lb_data,
    output logic          lb_sof,
    output logic          lb_eof,
    output logic          sent_pulse,
    output logic          underrun_pulse
);
    localparam int unsigned WORD_BYTES = DW / 8;

    logic          start;
    logic          walk_busy;
    logic          walk_done;
    logic [AW-1:0] base_addr;
    logic          beat_valid;
    logic          beat_ready;
    logic          to_loop;
    beat_t         beat;

    txd_cfg_regs #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .mac_tx_on  (mac_tx_on),
        .base_wr    (base_wr),
        .base_wdata (base_wdata),
        .kick_wr    (kick_wr),
        .kick_bit   (kick_bit),
        .walk_busy  (walk_busy),
        .walk_done  (walk_done),
        .base_addr  (base_addr),
        .dma_en     (dma_en),
        .start      (start)
    );

    txd_walk_fsm #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .EMPTY_BIT(EMPTY_BIT)) u_walk (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .base_addr      (base_addr),
        .loop_on        (loop_on),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_ack        (mem_ack),
        .mem_rdata      (mem_rdata),
        .beat_valid     (beat_valid),
        .beat           (beat),
        .to_loop        (to_loop),
        .beat_ready     (beat_ready),
        .sent_pulse     (sent_pulse),
        .underrun_pulse (underrun_pulse),
        .walk_busy      (walk_busy),
        .walk_done      (walk_done)
    );

    txd_out_steer u_steer (
        .beat_valid (beat_valid),
        .beat       (beat),
        .to_loop    (to_loop),
        .beat_ready (beat_ready),
        .line_valid (line_valid),
        .line_ready (line_ready),
        .line_data  (line_data),
        .line_sof   (line_sof),
        .line_eof   (line_eof),
        .lb_valid   (lb_valid),
        .lb_ready   (lb_ready),
        .lb_data    (lb_data),
        .lb_sof     (lb_sof),
        .lb_eof     (lb_eof)
    );
endmodule

// File: rtl/txd_chain_dma_chk.sv
module txd_chain_dma_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dma_en,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ack,
    input logic          line_valid,
    input logic          line_ready,
    input logic [7:0]    line_data,
    input logic          line_sof,
    input logic          line_eof,
    input logic          lb_valid,
    input logic          lb_ready,
    input logic [7:0]    lb_data,
    input logic          lb_sof,
    input logic          lb_eof,
    input logic          sent_pulse,
    input logic          underrun_pulse
);
    AST_BUS_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> dma_en);  // R1

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));  // R2

    AST_UNDERRUN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_pulse |=> (!dma_en && !mem_req));  // R3

    AST_SENT_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sent_pulse |=> (mem_req && !mem_we));  // R5

    AST_PULSES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(sent_pulse && underrun_pulse));  // R5

    AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_valid && lb_valid));  // R6

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !line_ready) |=>
            (line_valid && $stable(line_data) && $stable(line_sof) && $stable(line_eof)));  // R7

    AST_LB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_valid && !lb_ready) |=>
            (lb_valid && $stable(lb_data) && $stable(lb_sof) && $stable(lb_eof)));  // R7

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));  // R9
endmodule

bind txd_chain_dma txd_chain_dma_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/txd_chain_dma_test.sv
module txd_chain_dma_test;
    localparam int MEMW  = 1024;
    localparam int NF    = 36;
    localparam int NCAP  = 1024;
    localparam int LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mac_tx_on = 1'b0;
    logic        loop_on = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        kick_wr = 1'b0;
    logic        kick_bit = 1'b0;
    logic        dma_en;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        line_valid, line_sof, line_eof;
    logic        line_ready = 1'b1;
    logic [7:0]  line_data;
    logic        lb_valid, lb_sof, lb_eof;
    logic        lb_ready = 1'b1;
    logic [7:0]  lb_data;
    logic        sent_pulse, underrun_pulse;

    always #10 clk = ~clk;

    txd_chain_dma uut (
        .clk(clk), .rst_n(rst_n), .mac_tx_on(mac_tx_on), .loop_on(loop_on),
        .base_wr(base_wr), .base_wdata(base_wdata), .kick_wr(kick_wr), .kick_bit(kick_bit),
        .dma_en(dma_en), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .line_valid(line_valid), .line_ready(line_ready), .line_data(line_data),
        .line_sof(line_sof), .line_eof(line_eof), .lb_valid(lb_valid), .lb_ready(lb_ready),
        .lb_data(lb_data), .lb_sof(lb_sof), .lb_eof(lb_eof),
        .sent_pulse(sent_pulse), .underrun_pulse(underrun_pulse)
    );

    int errors = 0;
    int checks = 0;
    int lens [9] = '{5, 0, 1, 2, 3, 4, 7, 8, 13};

    logic [31:0] mem [0:MEMW-1];
    logic [31:0] rd_log [0:4095];
    int          rd_n = 0;
    int          req_cnt = 0;

    logic [7:0] cap_data [0:NCAP-1];
    logic       cap_sof  [0:NCAP-1];
    logic       cap_eof  [0:NCAP-1];
    logic       cap_lb   [0:NCAP-1];
    int         cap_n = 0;
    int         sent_n = 0;
    int         und_n = 0;
    int         stall_err = 0;
    bit         rdy_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit         stall_pend = 1'b0;
    logic [7:0] stall_d = '0;
    int         cyc = 0;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 13 + 5) & 255);
    endfunction
    function automatic int flen(input int i); return lens[i / 4]; endfunction
    function automatic int foff(input int i); return i % 4; endfunction
    function automatic int fbuf(input int i); return 32'h400 + i * 64 + foff(i); endfunction
    function automatic logic [31:0] fsz(input int i);
        return (32'(i) << 16) | (32'(i & 1) << 11) | 32'(flen(i));
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // memory model: acknowledges each request on the second edge
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            if (mem_req) req_cnt <= req_cnt + 1;
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) begin
                    mem[mem_addr[11:2]] <= mem_wdata;
                end else begin
                    mem_rdata <= mem[mem_addr[11:2]];
                    rd_log[rd_n] <= mem_addr;
                    rd_n <= rd_n + 1;
                end
            end
        end
    end

    // sinks: new readiness first, then record the transfer due at the next edge
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        line_ready = rdy_mode ? lfsr[0] : 1'b1;
        lb_ready   = rdy_mode ? lfsr[3] : 1'b1;
        if (stall_pend && !(line_valid && line_data == stall_d)) stall_err++;
        stall_pend = line_valid && !line_ready;
        stall_d    = line_data;
        if (cap_n < NCAP && ((line_valid && line_ready) || (lb_valid && lb_ready))) begin
            cap_data[cap_n] = line_valid ? line_data : lb_data;
            cap_sof[cap_n]  = line_valid ? line_sof : lb_sof;
            cap_eof[cap_n]  = line_valid ? line_eof : lb_eof;
            cap_lb[cap_n]   = lb_valid;
            cap_n++;
        end
        if (sent_pulse) sent_n++;
        if (underrun_pulse) und_n++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic init_mem();
        for (int w = 0; w < MEMW; w++) begin
            mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
        end
        for (int i = 0; i < NF; i++) begin
            mem[i*4]     = 32'(fbuf(i));
            mem[i*4 + 1] = fsz(i);
            mem[i*4 + 2] = 32'((i + 1) * 16);
        end
        mem[NF*4]     = 32'h0;
        mem[NF*4 + 1] = 32'h8000_0000;
        mem[NF*4 + 2] = 32'h0;
    endtask

    task automatic kick(input bit b);
        @(negedge clk); kick_wr = 1'b1; kick_bit = b;
        @(negedge clk); kick_wr = 1'b0; kick_bit = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (dma_en && t < 20000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
    endtask

    function automatic int exp_reads();
        int n = 2;
        for (int i = 0; i < NF; i++) begin
            n += 3;
            if (flen(i) > 0) n += ((foff(i) + flen(i) - 1) / 4) + 1;
        end
        return n;
    endfunction

    // frames with index below lbf are expected on the loopback stream
    task automatic check_stream(input int lbf, input string run);
        int idx = 0, total = 0, bad_d = 0, bad_m = 0, bad_s = 0, sofs = 0, nz = 0;
        int fa = 0, fe = 0;
        for (int i = 0; i < NF; i++) begin
            total += flen(i);
            if (flen(i) > 0) nz++;
        end
        check(cap_n == total, {"R4 byte count ", run}, cap_n, total);
        for (int i = 0; i < NF; i++) begin
            for (int b = 0; b < flen(i); b++) begin
                if (idx < cap_n) begin
                    if (cap_data[idx] != pat(fbuf(i) + b)) begin
                        if (bad_d == 0) begin fa = cap_data[idx]; fe = pat(fbuf(i) + b); end
                        bad_d++;
                    end
                    if (cap_sof[idx] != (b == 0) || cap_eof[idx] != (b == flen(i) - 1)) bad_m++;
                    if (cap_lb[idx] != (i < lbf)) bad_s++;
                    if (cap_sof[idx]) sofs++;
                end
                idx++;
            end
        end
        check(bad_d == 0, {"R4 byte data ", run}, fa, fe);
        check(bad_m == 0, {"R4 sof/eof markers ", run}, bad_m, 0);
        check(bad_s == 0, {"R6 sink selection ", run}, bad_s, 0);
        check(sofs == nz, {"R8 zero-length frames emit nothing ", run}, sofs, nz);
        check(sent_n == NF, {"R5 sent pulses ", run}, sent_n, NF);
        check(und_n == 1, {"R3 underrun pulses ", run}, und_n, 1);
    endtask

    initial begin
        int rd0;
        repeat (3) @(negedge clk);
        check(dma_en == 1'b0 && mem_req == 1'b0, "R11 reset dma_en/mem_req", {dma_en, mem_req}, 0);
        check(line_valid == 1'b0 && lb_valid == 1'b0, "R11 reset valids", {line_valid, lb_valid}, 0);
        rst_n = 1'b1;
        init_mem();
        @(negedge clk); base_wr = 1'b1; base_wdata = 32'h3;
        @(negedge clk); base_wr = 1'b0;

        // R1: enable written with MAC transmitter off
        kick(1'b1);
        repeat (20) @(negedge clk);
        check(dma_en == 1'b1, "R1 enable stored with MAC off", dma_en, 1);
        check(req_cnt == 0, "R1 no bus activity with MAC off", req_cnt, 0);

        // run 1: line, random readiness, ignored kick mid-walk
        mac_tx_on = 1'b1; loop_on = 1'b0; rdy_mode = 1'b1;
        cap_n = 0; sent_n = 0; und_n = 0; stall_err = 0;
        rd0 = rd_n;
        kick(1'b1);
        repeat (30) @(negedge clk);
        kick(1'b0);
        check(dma_en == 1'b1, "R10 enable write ignored while walking", dma_en, 1);
        wait_done();
        check(dma_en == 1'b0, "R3 enable cleared at end", dma_en, 0);
        check(rd_log[rd0] == 32'h0 && rd_log[rd0+1] == 32'h4 && rd_log[rd0+2] == 32'h8,
              "R2 aligned base and descriptor word order", rd_log[rd0+2], 8);
        check(rd_log[rd0+3] == (32'(fbuf(0)) & ~32'h3), "R4 first buffer fetch",
              rd_log[rd0+3], fbuf(0) & ~3);
        check(rd_n - rd0 == exp_reads(), "R3 R4 read count, no next read after empty",
              rd_n - rd0, exp_reads());
        check(rd_log[rd_n-1] == 32'(NF*16 + 4), "R3 last read is empty size word",
              rd_log[rd_n-1], NF*16 + 4);
        check_stream(0, "line");
        check(stall_err == 0, "R7 byte held while not ready", stall_err, 0);
        begin
            int bad = 0, fa = 0, fe = 0;
            for (int i = 0; i < NF; i++) begin
                if (mem[i*4 + 1] != (fsz(i) | 32'h8000_0000)) begin
                    if (bad == 0) begin fa = mem[i*4+1]; fe = fsz(i) | 32'h8000_0000; end
                    bad++;
                end
            end
            check(bad == 0, "R5 size word written back with bit 31", fa, fe);
            check(mem[NF*4 + 1] == 32'h8000_0000, "R3 empty descriptor untouched",
                  mem[NF*4 + 1], 32'h8000_0000);
        end

        // run 2: loopback throughout, random readiness
        init_mem();
        loop_on = 1'b1;
        cap_n = 0; sent_n = 0; und_n = 0;
        kick(1'b1);
        wait_done();
        check_stream(NF, "loopback");

        // run 3: loopback dropped during frame 0, which must stay on loopback
        init_mem();
        rdy_mode = 1'b0; loop_on = 1'b1;
        cap_n = 0; sent_n = 0; und_n = 0;
        kick(1'b1);
        while (cap_n == 0) @(negedge clk);
        loop_on = 1'b0;
        wait_done();
        check_stream(1, "switch");

        // run 4: head descriptor already empty after write-back
        cap_n = 0; sent_n = 0; und_n = 0;
        rd0 = rd_n;
        kick(1'b1);
        wait_done();
        check(und_n == 1 && sent_n == 0, "R3 immediate underrun", sent_n, 0);
        check(rd_n - rd0 == 2, "R3 only two reads on empty head", rd_n - rd0, 2);
        check(cap_n == 0, "R3 no bytes on empty head", cap_n, 0);
        check(dma_en == 1'b0, "R3 enable cleared", dma_en, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule